// File: doc/BRIEF.md
# Bus-Master Disk DMA Control Registers

This block is the register face of a single-channel bus-master disk DMA controller together with the small amount of sequencing that turns host register writes into engine control. A host reaches a command byte, a status byte and a 32-bit descriptor-table base address through a byte-wide register port. An external descriptor fetch and data-move engine takes its run level, direction and table base from the block. It reports completion or failure back to the block with single-cycle events.

The status byte mixes four kinds of bits. One bit is read-only and shows that a transfer is in progress. Two bits are sticky flags that record failure and pending interrupt, and the host clears each by writing 1 to it. Two bits are plain read/write per-drive "DMA capable" flags. The interrupt output follows the pending-interrupt flag. A transfer starts only when the run bit of the command byte changes from 0 to 1. Software judges a transfer good only when the low three status bits read `100` once it has stopped the engine.

Top module: `bmdma_regs`

## Requirements
- R1: After reset every register reads 0x00, and `irq`, `eng_start`, `eng_run`, `eng_to_mem` and `eng_table_base` are all 0.
- R2: Writing offset 0 with bit 0 = 1 while the run bit is 0 raises `eng_start` for exactly one cycle after the write edge, sets `eng_run`, and sets status bit 0 (active). Writing bit 0 = 1 while the run bit is already 1 gives no pulse.
- R3: Writing offset 0 with bit 0 = 0 clears the run bit (`eng_run`) and status bit 0.
- R4: Command bit 3 is the direction and drives `eng_to_mem` (1 = engine writes memory, 0 = engine reads memory). A write to offset 0 leaves bit 3 unchanged if status bit 0 is set at that write. Command reads return the run bit in bit 0, the direction in bit 3, and 0 in all other bits.
- R5: An `eng_done` pulse clears status bit 0 and sets status bit 2. A start write in the same cycle keeps bit 0 set.
- R6: An `eng_error` pulse sets status bits 1 and 2 and clears status bit 0.
- R7: Writing offset 2 with bit 1 or bit 2 = 1 clears that flag, and writing 0 to either leaves it unchanged. If an engine event sets a flag in the same cycle as the host clears it, the flag stays set.
- R8: Status bits 5 and 6 are read/write capability flags for drive 0 and drive 1. Status bit 0 cannot be written, and status bits 3, 4 and 7 read 0.
- R9: Offsets 4 to 7 hold the table base, least significant byte at offset 4. Bits 1:0 read as 0 whatever is written, and `eng_table_base` shows the stored value.
- R10: Offsets 1 and 3 read 0x00, and writes to them change nothing.
- R11: `irq` is high exactly while status bit 2 is set.
- R12: After a clean completion followed by a stop, status bits [2:0] read `100`. After an engine error they read `110`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_addr | input | 3 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| eng_start | output | 1 | One-cycle start request to the engine |
| eng_run | output | 1 | Engine run level (command bit 0) |
| eng_to_mem | output | 1 | Direction: 1 = engine writes memory |
| eng_table_base | output | 32 | Descriptor table base address |
| eng_done | input | 1 | Engine completion event |
| eng_error | input | 1 | Engine failure event |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 32-bit table pointer with 2 alignment bits and two drive capability flags. These values place every capability bit and every pointer byte in the 3-bit offset space, so all of them can be reached. With them the bench covers the full status byte, including the masked low pointer bits and both drive flags. It also exercises the direction lock during an active transfer, the start edge that fires only once, and the cases where an engine event and a host clear of the same flag land in the same cycle.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
    // register byte offsets (software decodes these)
    localparam logic [2:0] OFS_CMD  = 3'd0;
    localparam logic [2:0] OFS_STAT = 3'd2;
    localparam logic [2:0] OFS_PTR  = 3'd4;

    // command bit positions
    localparam int CMD_RUN = 0;
    localparam int CMD_DIR = 3;

    // status bit positions
    localparam int ST_ACT  = 0;
    localparam int ST_ERR  = 1;
    localparam int ST_INT  = 2;
    localparam int ST_CAP0 = 5;

    typedef struct packed {
        logic act;
        logic err;
        logic intr;
    } dma_flags_t;

    typedef struct packed {
        logic run;
        logic to_mem;
    } cmd_state_t;

    function automatic logic hits(input logic wr, input logic [2:0] addr,
                                  input logic [2:0] ofs);
        return wr && (addr == ofs);
    endfunction
endpackage

// File: rtl/bmdma_cmd_reg.sv
module bmdma_cmd_reg
    import bmdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_cmd,
    input  logic       run_bit,
    input  logic       dir_bit,
    input  logic       busy,
    output cmd_state_t cmd,
    output logic       start_req,
    output logic       stop_req,
    output logic       start_pulse
);
    cmd_state_t cmd_q;

    // a start is a 0->1 change of the run bit
    assign start_req = wr_cmd && run_bit && !cmd_q.run;
    assign stop_req  = wr_cmd && !run_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q       <= '0;
            start_pulse <= 1'b0;
        end else begin
            start_pulse <= start_req;
            if (wr_cmd) begin
                cmd_q.run <= run_bit;
                if (!busy)
                    cmd_q.to_mem <= dir_bit;
            end
        end
    end

    assign cmd = cmd_q;
endmodule

// File: rtl/bmdma_status_reg.sv
module bmdma_status_reg
    import bmdma_pkg::*;
#(
    parameter int NUM_DRV = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_req,
    input  logic               stop_req,
    input  logic               done_evt,
    input  logic               err_evt,
    input  logic               wr_stat,
    input  logic [1:0]         w1c_bits,   // [0]=error, [1]=interrupt
    input  logic [NUM_DRV-1:0] cap_bits,
    output dma_flags_t         flags,
    output logic [NUM_DRV-1:0] cap
);
    dma_flags_t fl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_q <= '0;
        end else begin
            if (start_req)
                fl_q.act <= 1'b1;
            else if (stop_req || done_evt || err_evt)
                fl_q.act <= 1'b0;

            if (err_evt)
                fl_q.err <= 1'b1;
            else if (wr_stat && w1c_bits[0])
                fl_q.err <= 1'b0;

            if (done_evt || err_evt)
                fl_q.intr <= 1'b1;
            else if (wr_stat && w1c_bits[1])
                fl_q.intr <= 1'b0;
        end
    end

    for (genvar d = 0; d < NUM_DRV; d++) begin : g_cap
        logic cap_q;
        always_ff @(posedge clk) begin
            if (rst)
                cap_q <= 1'b0;
            else if (wr_stat)
                cap_q <= cap_bits[d];
        end
        assign cap[d] = cap_q;
    end

    assign flags = fl_q;
endmodule

// File: rtl/bmdma_table_ptr.sv
module bmdma_table_ptr
    import bmdma_pkg::*;
#(
    parameter int PTR_W = 32,
    parameter int ALIGN = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [PTR_W-1:0] ptr
);
    localparam int PTR_BYTES = PTR_W / 8;

    logic [PTR_W-1:ALIGN] ptr_q;

    for (genvar b = 0; b < PTR_BYTES; b++) begin : g_byte
        localparam logic [2:0] MY_OFS = 3'(OFS_PTR + b);
        if (b == 0) begin : g_low
            always_ff @(posedge clk) begin
                if (rst)
                    ptr_q[7:ALIGN] <= '0;
                else if (hits(bus_wr, bus_addr, MY_OFS))
                    ptr_q[7:ALIGN] <= bus_wdata[7:ALIGN];
            end
        end else begin : g_full
            always_ff @(posedge clk) begin
                if (rst)
                    ptr_q[8*b +: 8] <= '0;
                else if (hits(bus_wr, bus_addr, MY_OFS))
                    ptr_q[8*b +: 8] <= bus_wdata;
            end
        end
    end

    assign ptr = {ptr_q, {ALIGN{1'b0}}};
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
    import bmdma_pkg::*;
#(
    parameter int PTR_W   = 32,
    parameter int ALIGN   = 2,
    parameter int NUM_DRV = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    output logic             eng_start,
    output logic             eng_run,
    output logic             eng_to_mem,
    output logic [PTR_W-1:0] eng_table_base,
    input  logic             eng_done,
    input  logic             eng_error,
    output logic             irq
);
    cmd_state_t         cmd;
    dma_flags_t         st_flags;
    logic [NUM_DRV-1:0] cap;
    logic               start_req;
    logic               stop_req;
    logic               wr_cmd;
    logic               wr_stat;

    assign wr_cmd  = hits(bus_wr, bus_addr, OFS_CMD);
    assign wr_stat = hits(bus_wr, bus_addr, OFS_STAT);

    bmdma_cmd_reg u_cmd (
        .clk         (clk),
        .rst         (rst),
        .wr_cmd      (wr_cmd),
        .run_bit     (bus_wdata[CMD_RUN]),
        .dir_bit     (bus_wdata[CMD_DIR]),
        .busy        (st_flags.act),
        .cmd         (cmd),
        .start_req   (start_req),
        .stop_req    (stop_req),
        .start_pulse (eng_start)
    );

    bmdma_status_reg #(.NUM_DRV(NUM_DRV)) u_stat (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .stop_req  (stop_req),
        .done_evt  (eng_done),
        .err_evt   (eng_error),
        .wr_stat   (wr_stat),
        .w1c_bits  (bus_wdata[ST_INT:ST_ERR]),
        .cap_bits  (bus_wdata[ST_CAP0 +: NUM_DRV]),
        .flags     (st_flags),
        .cap       (cap)
    );

    bmdma_table_ptr #(.PTR_W(PTR_W), .ALIGN(ALIGN)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ptr       (eng_table_base)
    );

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_addr == OFS_CMD) begin
            bus_rdata[CMD_RUN] = cmd.run;
            bus_rdata[CMD_DIR] = cmd.to_mem;
        end else if (bus_addr == OFS_STAT) begin
            bus_rdata[ST_ACT] = st_flags.act;
            bus_rdata[ST_ERR] = st_flags.err;
            bus_rdata[ST_INT] = st_flags.intr;
            for (int d = 0; d < NUM_DRV; d++)
                bus_rdata[ST_CAP0 + d] = cap[d];
        end else if (bus_addr[2]) begin
            bus_rdata = eng_table_base[{bus_addr[1:0], 3'b000} +: 8];
        end
    end

    assign eng_run    = cmd.run;
    assign eng_to_mem = cmd.to_mem;
    assign irq        = st_flags.intr;
endmodule

// File: rtl/bmdma_regs_chk.sv
module bmdma_regs_chk
    import bmdma_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       bus_wr,
    input logic [2:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       eng_start,
    input logic       eng_run,
    input logic       eng_to_mem,
    input logic       eng_done,
    input logic       eng_error,
    input logic       irq,
    input logic       st_act,
    input logic       st_err,
    input logic       st_int
);
    logic start_wr;
    logic stop_wr;
    logic err_clr_wr;

    assign start_wr   = bus_wr && bus_addr == OFS_CMD && bus_wdata[CMD_RUN] && !eng_run;
    assign stop_wr    = bus_wr && bus_addr == OFS_CMD && !bus_wdata[CMD_RUN];
    assign err_clr_wr = bus_wr && bus_addr == OFS_STAT && bus_wdata[ST_ERR];

    // R2
    start_one_shot_chk: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);

    // R2
    start_runs_chk: assert property (@(posedge clk) disable iff (rst)
        start_wr |=> eng_start && eng_run && st_act);

    // R3
    stop_chk: assert property (@(posedge clk) disable iff (rst)
        stop_wr |=> !eng_run && !st_act);

    // R4
    dir_lock_chk: assert property (@(posedge clk) disable iff (rst)
        st_act |=> $stable(eng_to_mem));

    // R5
    done_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_done && !start_wr) |=> !st_act && st_int);

    // R6
    error_chk: assert property (@(posedge clk) disable iff (rst)
        eng_error |=> st_err && st_int && !st_act);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (st_err && !eng_error && !err_clr_wr) |=> st_err);

    // R11
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(eng_done || eng_error));
endmodule

bind bmdma_regs bmdma_regs_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .eng_start  (eng_start),
    .eng_run    (eng_run),
    .eng_to_mem (eng_to_mem),
    .eng_done   (eng_done),
    .eng_error  (eng_error),
    .irq        (irq),
    .st_act     (st_flags.act),
    .st_err     (st_flags.err),
    .st_int     (st_flags.intr)
);

// File: tb/bmdma_regs_test.sv
`timescale 1ns/1ps
module bmdma_regs_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        eng_start, eng_run, eng_to_mem, irq;
    logic [31:0] eng_table_base;
    logic        eng_done = 1'b0;
    logic        eng_error = 1'b0;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    bmdma_regs uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_start(eng_start),
        .eng_run(eng_run), .eng_to_mem(eng_to_mem), .eng_table_base(eng_table_base),
        .eng_done(eng_done), .eng_error(eng_error), .irq(irq)
    );

    // {wr, addr[2:0]} nibble, data byte, expected byte, requirement number
    localparam int NVEC = 35;
    localparam logic [23:0] VEC [NVEC] = '{
        24'h0_00_00_1, // R1 command reads zero
        24'h2_00_00_1, // R1 status reads zero
        24'h4_00_00_1, // R1 pointer reads zero
        24'hC_AB_00_9, // R9 low pointer byte
        24'h4_00_A8_9, // R9 low two bits masked
        24'hD_12_00_9,
        24'hE_34_00_9,
        24'hF_56_00_9,
        24'h5_00_12_9, // R9
        24'h6_00_34_9, // R9
        24'h7_00_56_9, // R9
        24'hA_60_00_8, // R8 set both capability flags
        24'h2_00_60_8, // R8
        24'hA_9F_00_8, // R8 other bits not writable
        24'h2_00_00_8, // R8
        24'hA_20_00_8,
        24'h2_00_20_8, // R8 drive 0 only
        24'h9_FF_00_A, // R10 reserved offset 1
        24'hB_FF_00_A, // R10 reserved offset 3
        24'h1_00_00_A, // R10
        24'h3_00_00_A, // R10
        24'h2_00_20_A, // R10 status untouched
        24'h0_00_00_A, // R10 command untouched
        24'h8_08_00_4, // R4 direction while idle
        24'h0_00_08_4, // R4
        24'h8_09_00_2, // R2 start
        24'h2_00_21_2, // R2 active set
        24'h0_00_09_2, // R2
        24'h8_01_00_4, // R4 direction change while active
        24'h0_00_09_4, // R4 ignored
        24'h8_00_00_3, // R3 stop
        24'h2_00_20_3, // R3 active cleared
        24'h0_00_08_3, // R3 run cleared, direction kept
        24'h8_00_00_4,
        24'h0_00_00_4  // R4 writable once idle
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int req, input logic [2:0] a, input logic [7:0] exp);
        bus_addr = a;
        #2;
        check(req, {24'h0, bus_rdata}, {24'h0, exp});
    endtask

    task automatic pulse_done();
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
    endtask

    task automatic pulse_err();
        @(negedge clk); eng_error = 1'b1;
        @(negedge clk); eng_error = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 outputs after reset
        check(1, {28'h0, irq, eng_start, eng_run, eng_to_mem}, 32'h0);
        check(1, eng_table_base, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][23])
                wr(VEC[i][22:20], VEC[i][19:12]);
            else
                rd(int'(VEC[i][3:0]), VEC[i][22:20], VEC[i][11:4]);
        end

        // R9 pointer output
        check(9, eng_table_base, 32'h563412A8);

        // R2 one-shot start pulse
        wr(3'd0, 8'h01);
        check(2, {30'h0, eng_start, eng_run}, 32'h3);
        @(negedge clk);
        check(2, {31'h0, eng_start}, 32'h0);
        wr(3'd0, 8'h01);
        check(2, {31'h0, eng_start}, 32'h0);

        // R5 completion, R11 interrupt
        pulse_done();
        rd(5, 3'd2, 8'h24);
        check(11, {31'h0, irq}, 32'h1);
        wr(3'd0, 8'h00);
        bus_addr = 3'd2; #2;
        check(12, {29'h0, bus_rdata[2:0]}, 32'h4); // R12 clean pattern
        // R7 write 0 keeps flag, write 1 clears
        wr(3'd2, 8'h20);
        rd(7, 3'd2, 8'h24);
        wr(3'd2, 8'h24);
        rd(7, 3'd2, 8'h20);
        check(11, {31'h0, irq}, 32'h0);

        // R6 error path
        wr(3'd0, 8'h01);
        pulse_err();
        rd(6, 3'd2, 8'h26);
        check(11, {31'h0, irq}, 32'h1);
        wr(3'd0, 8'h00);
        bus_addr = 3'd2; #2;
        check(12, {29'h0, bus_rdata[2:0]}, 32'h6); // R12 failure pattern
        wr(3'd2, 8'h22);
        rd(7, 3'd2, 8'h24);
        wr(3'd2, 8'h24);
        rd(7, 3'd2, 8'h20);

        // R7 event and host clear in the same cycle: event wins
        wr(3'd0, 8'h01);
        @(negedge clk);
        eng_done = 1'b1; bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 8'h24;
        @(negedge clk);
        eng_done = 1'b0; bus_wr = 1'b0;
        rd(7, 3'd2, 8'h24);
        @(negedge clk);
        eng_error = 1'b1; bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 8'h26;
        @(negedge clk);
        eng_error = 1'b0; bus_wr = 1'b0;
        rd(7, 3'd2, 8'h26);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule